// File: doc/BRIEF.md
# Pause Watermark Hysteresis Controller

This block decides when a port asks its link partner to stop sending. Each cycle it compares the port's buffer fill level, counted in buffer cells, against two stored thresholds: a start level and a stop level. The request turns on when the fill reaches the start level. It turns off only after the fill drops below the stop level. Between the two levels the request keeps its previous value, so the gap between the levels gives hysteresis.

The thresholds are written in bytes through a small configuration port. A combinational encoder turns the byte value into a compact 9-bit code before it is stored. The code is either a plain cell count up to 255, or a count of 16-cell units marked by a scale flag and saturated at 255 units. A decoder expands each stored code back to cells for the comparison.

On each edge of the request the block emits a one-cycle strobe and a 16-bit pause value for the frame generator. A rising request carries the maximum value. A falling request carries a zero value, and only when zero-value release is enabled. A global enable forces the request low.

Top module: `fc_wmark_pause`

## Requirements
- R1: A threshold of B bytes is encoded from the cell count C = floor(B / CELL_BYTES), with CELL_BYTES = 64 by default. When C < 256 the stored 9-bit code has bit 8 clear and bits 7:0 equal to C. The stored code is visible on `wm_start_code` or `wm_stop_code` from the cycle after the write.
- R2: When C >= 256 the code has bit 8 set and bits 7:0 equal to floor(C / 16). A code with bit 8 set therefore never has bits 7:0 below 16.
- R3: When floor(C / 16) exceeds 255, bits 7:0 saturate to 255, which gives the code 0x1FF.
- R4: After reset the start code is the encoding of 9108 bytes (0x08E) and the stop code is the encoding of 6072 bytes (0x05E). `pause_req`, both strobes and `pause_val` are 0.
- R5: A code is decoded to cells as bits 7:0, multiplied by 16 when bit 8 is set. While `enable` is high and `fill_cells` is at or above the decoded start level, `pause_req` is 1 in the following cycle.
- R6: While `enable` is high and `fill_cells` is below both decoded levels, `pause_req` is 0 in the following cycle. When the fill is at or above the stop level and below the start level, `pause_req` keeps its value.
- R7: While `enable` is low, `pause_req` is 0 in the following cycle, whatever the fill level.
- R8: In the cycle when `pause_req` rises, `xoff_stb` is 1 for exactly that cycle and `pause_val` is 0xFFFF.
- R9: In the cycle when `pause_req` falls, `xon_stb` is 1 for that cycle with `pause_val` 0, but only if `zero_rel_en` was high at the clock edge that cleared the request. Otherwise no strobe occurs. Outside strobe cycles `pause_val` is 0.
- R10: `pause_req` is registered. A change of `fill_cells` shows on it after one clock edge, and a threshold write only affects comparisons from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable for pause generation |
| zero_rel_en | input | 1 | Emit a zero-value pause on release |
| fill_cells | input | FILL_W (14) | Current buffer fill in cells |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | Threshold written: 0 start, 1 stop |
| cfg_bytes | input | BYTE_W (20) | Threshold in bytes |
| pause_req | output | 1 | Pause request level |
| xoff_stb | output | 1 | One-cycle strobe when the request rises |
| xon_stb | output | 1 | One-cycle strobe when the request falls (zero release) |
| pause_val | output | 16 | Pause value carried with a strobe |
| wm_start_code | output | 9 | Stored start threshold code |
| wm_stop_code | output | 9 | Stored stop threshold code |

## Verification
A wrong encoding shows directly on the code outputs one cycle after a write. It also moves the fill level at which the request switches, and a one-cell sweep around the decoded level exposes that on the next edge. A corrupted hysteresis state shows as a request that drops or rises inside the band between the two levels, and this is visible in the first cycle of the error. Strobe faults appear as a missing or repeated pulse, or a wrong value, in the same cycle as the request edge.

// File: rtl/fcwm_pkg.sv
package fcwm_pkg;

    localparam int MANT_W   = 8;
    localparam int SCALE_LG = 4;
    localparam int DEC_W    = MANT_W + SCALE_LG;
    localparam int PVAL_W   = 16;
    localparam logic [PVAL_W-1:0] PVAL_STOP = '1;

    // Stored threshold code: bit 8 = scale flag (x16), bits 7:0 = mantissa
    typedef struct packed {
        logic              scaled;
        logic [MANT_W-1:0] mant;
    } wm_code_t;

    typedef enum logic {
        WM_START = 1'b0,
        WM_STOP  = 1'b1
    } wm_sel_e;

    typedef struct packed {
        logic req;
        logic rise_stb;
        logic fall_stb;
    } pause_evt_t;

    function automatic wm_code_t wm_encode(input logic [31:0] cells);
        wm_code_t    c;
        logic [31:0] units;
        if (cells < (32'd1 << MANT_W)) begin
            c.scaled = 1'b0;
            c.mant   = cells[MANT_W-1:0];
        end else begin
            units = cells >> SCALE_LG;
            if (units >= (32'd1 << MANT_W))
                units = (32'd1 << MANT_W) - 32'd1;
            c.scaled = 1'b1;
            c.mant   = units[MANT_W-1:0];
        end
        return c;
    endfunction

    function automatic logic [DEC_W-1:0] wm_decode(input wm_code_t c);
        if (c.scaled)
            return {c.mant, {SCALE_LG{1'b0}}};
        else
            return DEC_W'(c.mant);
    endfunction

endpackage

// File: rtl/fcwm_encoder.sv
module fcwm_encoder
    import fcwm_pkg::*;
#(
    parameter int CELL_BYTES = 64,
    parameter int BYTE_W     = 20
) (
    input  logic [BYTE_W-1:0] bytes_i,
    output wm_code_t          code_o
);
    localparam int CELL_LG = $clog2(CELL_BYTES);

    logic [31:0] cells;

    generate
        if (CELL_BYTES == (1 << CELL_LG)) begin : g_pow2
            assign cells = 32'(bytes_i) >> CELL_LG;
        end else begin : g_div
            assign cells = 32'(bytes_i) / 32'(CELL_BYTES);
        end
    endgenerate

    assign code_o = wm_encode(cells);

endmodule

// File: rtl/fcwm_store.sv
module fcwm_store
    import fcwm_pkg::*;
#(
    parameter int CELL_BYTES  = 64,
    parameter int START_BYTES = 6 * 1518,
    parameter int STOP_BYTES  = 4 * 1518
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  wm_sel_e  sel,
    input  wm_code_t code_in,
    output wm_code_t start_q,
    output wm_code_t stop_q
);
    localparam wm_code_t RST_START = wm_encode(32'(START_BYTES / CELL_BYTES));
    localparam wm_code_t RST_STOP  = wm_encode(32'(STOP_BYTES / CELL_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= RST_START;
            stop_q  <= RST_STOP;
        end else if (we) begin
            if (sel == WM_START) start_q <= code_in;
            else                 stop_q  <= code_in;
        end
    end

endmodule

// File: rtl/fcwm_hyst.sv
module fcwm_hyst
    import fcwm_pkg::*;
#(
    parameter int FILL_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              zero_rel_en,
    input  logic [FILL_W-1:0] fill,
    input  wm_code_t          start_code,
    input  wm_code_t          stop_code,
    output pause_evt_t        evt_q
);
    localparam int CMP_W = (FILL_W > DEC_W) ? FILL_W : DEC_W;

    logic [CMP_W-1:0] fill_x, start_x, stop_x;
    logic             req_d;

    assign fill_x  = CMP_W'(fill);
    assign start_x = CMP_W'(wm_decode(start_code));
    assign stop_x  = CMP_W'(wm_decode(stop_code));

    always_comb begin
        if (!enable)               req_d = 1'b0;
        else if (fill_x >= start_x) req_d = 1'b1;
        else if (fill_x < stop_x)   req_d = 1'b0;
        else                        req_d = evt_q.req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.req      <= req_d;
            evt_q.rise_stb <= req_d & ~evt_q.req;
            evt_q.fall_stb <= ~req_d & evt_q.req & zero_rel_en;
        end
    end

endmodule

// File: rtl/fc_wmark_pause.sv
module fc_wmark_pause
    import fcwm_pkg::*;
#(
    parameter int CELL_BYTES  = 64,
    parameter int BYTE_W      = 20,
    parameter int FILL_W      = 14,
    parameter int START_BYTES = 6 * 1518,
    parameter int STOP_BYTES  = 4 * 1518
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  zero_rel_en,
    input  logic [FILL_W-1:0]     fill_cells,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [BYTE_W-1:0]     cfg_bytes,
    output logic                  pause_req,
    output logic                  xoff_stb,
    output logic                  xon_stb,
    output logic [PVAL_W-1:0]     pause_val,
    output logic [MANT_W:0]       wm_start_code,
    output logic [MANT_W:0]       wm_stop_code
);
    wm_code_t   enc_code, start_q, stop_q;
    pause_evt_t evt;
    wm_sel_e    sel;

    assign sel = wm_sel_e'(cfg_sel);

    fcwm_encoder #(
        .CELL_BYTES (CELL_BYTES),
        .BYTE_W     (BYTE_W)
    ) u_enc (
        .bytes_i (cfg_bytes),
        .code_o  (enc_code)
    );

    fcwm_store #(
        .CELL_BYTES  (CELL_BYTES),
        .START_BYTES (START_BYTES),
        .STOP_BYTES  (STOP_BYTES)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .sel     (sel),
        .code_in (enc_code),
        .start_q (start_q),
        .stop_q  (stop_q)
    );

    fcwm_hyst #(
        .FILL_W (FILL_W)
    ) u_hyst (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .zero_rel_en (zero_rel_en),
        .fill        (fill_cells),
        .start_code  (start_q),
        .stop_code   (stop_q),
        .evt_q       (evt)
    );

    assign pause_req     = evt.req;
    assign xoff_stb      = evt.rise_stb;
    assign xon_stb       = evt.fall_stb;
    assign pause_val     = evt.rise_stb ? PVAL_STOP : '0;
    assign wm_start_code = start_q;
    assign wm_stop_code  = stop_q;

endmodule

// File: rtl/fc_wmark_pause_chk.sv
module fc_wmark_pause_chk
    import fcwm_pkg::*;
#(
    parameter int FILL_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              zero_rel_en,
    input logic [FILL_W-1:0] fill_cells,
    input logic              pause_req,
    input logic              xoff_stb,
    input logic              xon_stb,
    input logic [PVAL_W-1:0] pause_val,
    input logic [MANT_W:0]   wm_start_code,
    input logic [MANT_W:0]   wm_stop_code
);
    logic [31:0] start_cells, stop_cells;
    assign start_cells = wm_start_code[MANT_W] ? 32'(wm_start_code[MANT_W-1:0]) * 32'd16
                                               : 32'(wm_start_code[MANT_W-1:0]);
    assign stop_cells  = wm_stop_code[MANT_W]  ? 32'(wm_stop_code[MANT_W-1:0]) * 32'd16
                                               : 32'(wm_stop_code[MANT_W-1:0]);

    assert_scaled_floor_R2: assert property (@(posedge clk) disable iff (rst)
        wm_start_code[MANT_W] |-> (wm_start_code[MANT_W-1:0] >= 8'd16));

    assert_set_at_start_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && 32'(fill_cells) >= start_cells) |=> pause_req);

    assert_clear_below_R6: assert property (@(posedge clk) disable iff (rst)
        (enable && 32'(fill_cells) < stop_cells && 32'(fill_cells) < start_cells) |=> !pause_req);

    assert_disable_low_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pause_req);

    assert_rise_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pause_req) |-> (xoff_stb && pause_val == 16'hFFFF));

    assert_rise_only_R8: assert property (@(posedge clk) disable iff (rst)
        xoff_stb |-> $rose(pause_req));

    assert_fall_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        xon_stb |-> ($fell(pause_req) && $past(zero_rel_en) && pause_val == 16'h0000));

    assert_strobes_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(xoff_stb && xon_stb));

endmodule

bind fc_wmark_pause fc_wmark_pause_chk #(.FILL_W(FILL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .zero_rel_en   (zero_rel_en),
    .fill_cells    (fill_cells),
    .pause_req     (pause_req),
    .xoff_stb      (xoff_stb),
    .xon_stb       (xon_stb),
    .pause_val     (pause_val),
    .wm_start_code (wm_start_code),
    .wm_stop_code  (wm_stop_code)
);

// File: tb/fc_wmark_pause_bench.sv
module fc_wmark_pause_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        zero_rel_en = 1'b1;
    logic [13:0] fill_cells = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [19:0] cfg_bytes = '0;
    logic        pause_req, xoff_stb, xon_stb;
    logic [15:0] pause_val;
    logic [8:0]  wm_start_code, wm_stop_code;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fc_wmark_pause u_fc_wmark_pause (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .zero_rel_en   (zero_rel_en),
        .fill_cells    (fill_cells),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_bytes     (cfg_bytes),
        .pause_req     (pause_req),
        .xoff_stb      (xoff_stb),
        .xon_stb       (xon_stb),
        .pause_val     (pause_val),
        .wm_start_code (wm_start_code),
        .wm_stop_code  (wm_stop_code)
    );

    // {fill, req, xoff, xon} with defaults start 142 cells, stop 94 cells
    localparam int NV = 10;
    localparam logic [16:0] VEC [NV] = '{
        {14'd50,  1'b0, 1'b0, 1'b0},
        {14'd141, 1'b0, 1'b0, 1'b0},
        {14'd142, 1'b1, 1'b1, 1'b0},
        {14'd142, 1'b1, 1'b0, 1'b0},
        {14'd120, 1'b1, 1'b0, 1'b0},
        {14'd94,  1'b1, 1'b0, 1'b0},
        {14'd93,  1'b0, 1'b0, 1'b1},
        {14'd120, 1'b0, 1'b0, 1'b0},
        {14'd200, 1'b1, 1'b1, 1'b0},
        {14'd0,   1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [13:0] f);
        fill_cells = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [19:0] b);
        cfg_we = 1'b1; cfg_sel = sel; cfg_bytes = b;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R4 reset state
        check("R4 start code", 32'(wm_start_code), 32'h08E);
        check("R4 stop code",  32'(wm_stop_code),  32'h05E);
        check("R4 req", 32'(pause_req), 0);
        check("R4 strobes", {30'd0, xoff_stb, xon_stb}, 0);
        check("R4 value", 32'(pause_val), 0);

        enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16:3]);
            check("R5/R6/R10 req", 32'(pause_req), 32'(VEC[i][2]));
            check("R8 xoff", 32'(xoff_stb), 32'(VEC[i][1]));
            check("R9 xon", 32'(xon_stb), 32'(VEC[i][0]));
            check("R8/R9 value", 32'(pause_val), VEC[i][1] ? 32'hFFFF : 32'h0);
        end

        // Encoder corners
        wr(1'b0, 20'd16383);
        check("R1 255 cells", 32'(wm_start_code), 32'h0FF);
        wr(1'b0, 20'd16384);
        check("R2 256 cells", 32'(wm_start_code), 32'h110);
        wr(1'b0, 20'd20000);
        check("R2 312 cells", 32'(wm_start_code), 32'h113);
        check("R1 stop untouched", 32'(wm_stop_code), 32'h05E);

        // R5 decoded scaled level 304 cells
        step(14'd303);
        check("R5 below scaled start", 32'(pause_req), 0);
        step(14'd304);
        check("R5 at scaled start", 32'(pause_req), 1);
        check("R8 xoff scaled", 32'(pause_val), 32'hFFFF);

        // R3 saturation -> 4080 cells
        wr(1'b0, 20'hFFFFF);
        check("R3 saturated code", 32'(wm_start_code), 32'h1FF);
        step(14'd0);
        step(14'd4079);
        check("R3 below 4080", 32'(pause_req), 0);
        step(14'd4080);
        check("R3 at 4080", 32'(pause_req), 1);

        // R7 disable forces low
        enable = 1'b0;
        step(14'd5000);
        check("R7 req low", 32'(pause_req), 0);
        check("R9 xon on disable", 32'(xon_stb), 1);
        step(14'd6000);
        check("R7 held low", 32'(pause_req), 0);
        check("R9 single pulse", 32'(xon_stb), 0);
        enable = 1'b1;

        // R9 release without zero-value pause
        step(14'd4080);
        check("R8 re-rise", 32'(xoff_stb), 1);
        zero_rel_en = 1'b0;
        step(14'd10);
        check("R6 cleared", 32'(pause_req), 0);
        check("R9 no xon", 32'(xon_stb), 0);
        check("R9 value zero", 32'(pause_val), 0);

        // R10 write takes effect on next edge: lower start to 100 cells
        wr(1'b0, 20'd6400);
        check("R1 100 cells", 32'(wm_start_code), 32'h064);
        step(14'd100);
        check("R10 new start used", 32'(pause_req), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule